// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is a free-running up-counter with four compare channels. A base tick input, nominally 16 MHz, passes through a power-of-two prescaler, and each prescaled tick advances the counter by one. The counter width can be set to 8, 16, 24 or 32 bits, and the counter wraps from all-ones back to zero at the selected width. Each channel holds a compare value. When the counter steps onto that value, the channel sets a sticky event flag.

Software controls the block over a simple 32-bit register bus that is addressed by word index. Writing 1 to one of three trigger registers starts, halts or zeroes the counter. Writing any value to a trigger register reads back as 0. Each event flag can be read, and a write with bit 0 low clears it. A compare value that is already behind the counter does not fire immediately. It fires only after the counter wraps around and climbs back up to that value.

Top module: `tmr4_compare_timer`

## Requirements
- R1: After reset the counter reads 0, all four event flags read 0, the width code reads 0, the prescale reads 0 and the timer is halted.
- R2: A write with bit 0 set to index 0 starts counting from the next cycle. A write with bit 0 clear to any trigger index has no effect.
- R3: A write with bit 0 set to index 1 halts the counter. While halted, the counter keeps its value. A later start resumes from that held value.
- R4: A write with bit 0 set to index 2 zeroes both the counter and the prescale divider. When this coincides with a counting step, zeroing wins.
- R5: Index 4 holds the prescale value P, and the counter advances once every 2^P base ticks. A written value above 9 is stored and read back as 9.
- R6: Index 3 bits [1:0] select the width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. The counter wraps from the all-ones value of that width to 0. The count at index 5 reads masked to the selected width.
- R7: Channel i (0 to 3) holds its compare value at index 8+i. Its flag sets when a counting step brings the counter to that value, masked to the width. The flag reads as bit 0 of index 12+i and drives cmpEvent[i].
- R8: An event flag stays set until a write with bit 0 clear reaches its index. A write with bit 0 set to a flag index leaves the flag unchanged.
- R9: When a compare hit and a clearing write to the same flag fall in one cycle, the flag ends up set.
- R10: A compare value below the current count raises no event until the counter has wrapped and reached that value.
- R11: Reads of indices 0 to 2, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | Base tick enable, one clock wide per tick |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word index |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| cmpEvent | output | 4 | Sticky compare event flags |

## Verification
Two pairs of actions can land in the same clock edge. The first pair is a software write that clears a flag and a compare hit on that same flag. To provoke it, the bench holds a clearing write on channel 3 for several hundred cycles while an 8-bit counter wraps past the compare value more than once. Every hit then collides with a clear, and the bench expects the flag to read high in the cycle after each hit. The second pair is the zeroing trigger and a counting step, which the bench provokes by zeroing while ticks arrive every cycle. For both pairs, the per-clock reference model and explicit reads judge the result.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;

  localparam int CH_COUNT = 4;
  localparam int CNT_W    = 32;

  // Register word indices on the bus
  localparam int IDX_START    = 0;
  localparam int IDX_STOP     = 1;
  localparam int IDX_CLEAR    = 2;
  localparam int IDX_WIDTH    = 3;
  localparam int IDX_PRESC    = 4;
  localparam int IDX_COUNT    = 5;
  localparam int IDX_CC_BASE  = 8;
  localparam int IDX_EVT_BASE = IDX_CC_BASE + CH_COUNT;

  typedef enum logic [1:0] {
    WID_16 = 2'd0,
    WID_8  = 2'd1,
    WID_24 = 2'd2,
    WID_32 = 2'd3
  } widSel_e;

  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic                goRun;
    logic                haltRun;
    logic                zeroCnt;
    logic [CH_COUNT-1:0] dropEvt;
  } tmrStrobe_t;

  function automatic logic [CNT_W-1:0] widthMask(widSel_e w);
    case (w)
      WID_8:   return CNT_W'(32'h0000_00FF);
      WID_24:  return CNT_W'(32'h00FF_FFFF);
      WID_32:  return '1;
      default: return CNT_W'(32'h0000_FFFF);
    endcase
  endfunction

endpackage

// File: rtl/tmr4_chan.sv
module tmr4_chan
  import tmr4_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic [CNT_W-1:0] cntNext,
  input  logic [CNT_W-1:0] widMask,
  input  logic [CNT_W-1:0] ccVal,
  input  logic             dropEvt,
  output logic             evtFlag
);

  logic hit;

  // A hit only counts on a real counting step
  assign hit = advance && (cntNext == (ccVal & widMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
    end else if (hit) begin
      evtFlag <= 1'b1;        // hardware set wins over software clear
    end else if (dropEvt) begin
      evtFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr4_ctrl.sv
module tmr4_ctrl
  import tmr4_pkg::*;
#(
  parameter  int ADDR_W = 4,
  parameter  int PS_MAX = 9,
  localparam int PS_W   = $clog2(PS_MAX + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWrEn,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [31:0]                   busWrData,
  input  logic [CNT_W-1:0]              cntVal,
  input  logic [CH_COUNT-1:0]           evtFlags,
  output tmrStrobe_t                    strobe,
  output widSel_e                       widSel,
  output logic [PS_W-1:0]               prescale,
  output logic [CH_COUNT-1:0][CNT_W-1:0] ccVal,
  output logic [31:0]                   busRdData
);

  logic trigBit;
  assign trigBit = busWrData[0];

  // Trigger and flag-clear decode
  always_comb begin
    strobe = '0;
    if (busWrEn && trigBit) begin
      if (busAddr == ADDR_W'(IDX_START)) strobe.goRun   = 1'b1;
      if (busAddr == ADDR_W'(IDX_STOP))  strobe.haltRun = 1'b1;
      if (busAddr == ADDR_W'(IDX_CLEAR)) strobe.zeroCnt = 1'b1;
    end
    for (int ch = 0; ch < CH_COUNT; ch++) begin
      if (busWrEn && !trigBit && (busAddr == ADDR_W'(IDX_EVT_BASE + ch)))
        strobe.dropEvt[ch] = 1'b1;
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widSel   <= WID_16;
      prescale <= '0;
    end else if (busWrEn) begin
      if (busAddr == ADDR_W'(IDX_WIDTH))
        widSel <= widSel_e'(busWrData[1:0]);
      if (busAddr == ADDR_W'(IDX_PRESC)) begin
        if (busWrData > 32'(PS_MAX)) prescale <= PS_W'(PS_MAX);
        else                         prescale <= busWrData[PS_W-1:0];
      end
    end
  end

  // Compare value registers, one per channel
  for (genvar gc = 0; gc < CH_COUNT; gc++) begin : g_cc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ccVal[gc] <= '0;
      end else if (busWrEn && (busAddr == ADDR_W'(IDX_CC_BASE + gc))) begin
        ccVal[gc] <= busWrData[CNT_W-1:0];
      end
    end
  end

  // Read multiplexer
  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(IDX_WIDTH)) busRdData = 32'(widSel);
    if (busAddr == ADDR_W'(IDX_PRESC)) busRdData = 32'(prescale);
    if (busAddr == ADDR_W'(IDX_COUNT)) busRdData = 32'(cntVal);
    for (int ch = 0; ch < CH_COUNT; ch++) begin
      if (busAddr == ADDR_W'(IDX_CC_BASE + ch))  busRdData = 32'(ccVal[ch]);
      if (busAddr == ADDR_W'(IDX_EVT_BASE + ch)) busRdData = {31'b0, evtFlags[ch]};
    end
  end

endmodule

// File: rtl/tmr4_datapath.sv
module tmr4_datapath
  import tmr4_pkg::*;
#(
  parameter  int PS_MAX = 9,
  localparam int PS_W   = $clog2(PS_MAX + 1),
  localparam int DIV_W  = (PS_MAX > 0) ? PS_MAX : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickIn,
  input  tmrStrobe_t                     strobe,
  input  widSel_e                        widSel,
  input  logic [PS_W-1:0]                prescale,
  input  logic [CH_COUNT-1:0][CNT_W-1:0] ccVal,
  output logic [CNT_W-1:0]               cntVal,
  output logic [CH_COUNT-1:0]            evtFlags,
  output logic                           running
);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0]   divSpan;
  logic [DIV_W-1:0] divMask;
  logic             divDone;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] widMask;
  logic [CNT_W-1:0] cntNext;
  logic             advance;

  assign widMask = widthMask(widSel);
  assign divSpan = (DIV_W + 1)'(1) << prescale;
  assign divMask = DIV_W'(divSpan - (DIV_W + 1)'(1));
  // >= keeps the divider from running away after prescale shrinks
  assign divDone = (divCnt >= divMask);
  assign advance = running && tickIn && divDone && !strobe.zeroCnt;
  assign cntNext = (cnt + CNT_W'(1)) & widMask;
  assign cntVal  = cnt & widMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (strobe.goRun) begin
      running <= 1'b1;
    end else if (strobe.haltRun) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.zeroCnt) begin
      divCnt <= '0;
    end else if (running && tickIn) begin
      divCnt <= divDone ? '0 : divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.zeroCnt) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= cntNext;
    end
  end

  for (genvar gc = 0; gc < CH_COUNT; gc++) begin : g_chan
    tmr4_chan i_chan (
      .clk     (clk),
      .rstN    (rstN),
      .advance (advance),
      .cntNext (cntNext),
      .widMask (widMask),
      .ccVal   (ccVal[gc]),
      .dropEvt (strobe.dropEvt[gc]),
      .evtFlag (evtFlags[gc])
    );
  end

endmodule

// File: rtl/tmr4_compare_timer.sv
module tmr4_compare_timer
  import tmr4_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PS_MAX = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [CH_COUNT-1:0] cmpEvent
);

  localparam int PS_W = $clog2(PS_MAX + 1);

  tmrStrobe_t                     strobe;
  widSel_e                        widSel;
  logic [PS_W-1:0]                prescale;
  logic [CH_COUNT-1:0][CNT_W-1:0] ccVal;
  logic [CNT_W-1:0]               cntVal;
  logic                           running;

  tmr4_ctrl #(.ADDR_W(ADDR_W), .PS_MAX(PS_MAX)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .cntVal    (cntVal),
    .evtFlags  (cmpEvent),
    .strobe    (strobe),
    .widSel    (widSel),
    .prescale  (prescale),
    .ccVal     (ccVal),
    .busRdData (busRdData)
  );

  tmr4_datapath #(.PS_MAX(PS_MAX)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .strobe   (strobe),
    .widSel   (widSel),
    .prescale (prescale),
    .ccVal    (ccVal),
    .cntVal   (cntVal),
    .evtFlags (cmpEvent),
    .running  (running)
  );

endmodule

// File: rtl/tmr4_timer_checker.sv
module tmr4_timer_checker
  import tmr4_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickIn,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                wrBit0,
  input logic [CH_COUNT-1:0] cmpEvent,
  input logic [CNT_W-1:0]    cntVal,
  input logic                running
);

  // R4: a zeroing trigger leaves the counter at 0
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && wrBit0 && busAddr == ADDR_W'(IDX_CLEAR)) |=> (cntVal == '0));

  // R3: a halted counter holds unless zeroed or re-masked
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !(busWrEn && (busAddr == ADDR_W'(IDX_CLEAR) ||
                               busAddr == ADDR_W'(IDX_WIDTH))))
    |=> $stable(cntVal));

  for (genvar gc = 0; gc < CH_COUNT; gc++) begin : g_flag
    // R8: a set flag survives unless a clearing write reaches it
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cmpEvent[gc] && !(busWrEn && !wrBit0 && busAddr == ADDR_W'(IDX_EVT_BASE + gc)))
      |=> cmpEvent[gc]);

    // R7: a flag rises only after a counting cycle with a tick
    p_flag_needs_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cmpEvent[gc]) |-> $past(running && tickIn));
  end

endmodule

bind tmr4_compare_timer tmr4_timer_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .tickIn   (tickIn),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .wrBit0   (busWrData[0]),
  .cmpEvent (cmpEvent),
  .cntVal   (cntVal),
  .running  (running)
);

// File: tb/test_tmr4_compare_timer.sv
module test_tmr4_compare_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickIn;
  logic        busWrEn;
  logic [3:0]  busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [3:0]  cmpEvent;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  bit done   = 0;
  bit tickGap = 0;
  bit flagSeen;

  // Reference model state
  bit              mRun;
  int unsigned     mDiv;
  longint unsigned mCnt;
  bit [3:0]        mEvt;
  int unsigned     mWid;
  int unsigned     mPs;
  longint unsigned mCc [4];

  tmr4_compare_timer i_tmr4_compare_timer (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cmpEvent  (cmpEvent)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint unsigned maskOf(int unsigned w);
    case (w)
      1: return 64'hFF;
      2: return 64'hFF_FFFF;
      3: return 64'hFFFF_FFFF;
      default: return 64'hFFFF;
    endcase
  endfunction

  function automatic longint unsigned modelRead(int a);
    if (a == 3) return mWid;
    if (a == 4) return mPs;
    if (a == 5) return mCnt & maskOf(mWid);
    if (a >= 8 && a < 12) return mCc[a - 8];
    if (a >= 12 && a < 16) return mEvt[a - 12];
    return 0;
  endfunction

  always @(posedge clk) begin : model
    bit wr, clr, adv;
    int a;
    longint unsigned d, msk, dmask, nxt;
    if (!rstN) begin
      mRun = 0; mDiv = 0; mCnt = 0; mEvt = '0; mWid = 0; mPs = 0;
      for (int i = 0; i < 4; i++) mCc[i] = 0;
    end else begin
      wr    = busWrEn;
      a     = int'(busAddr);
      d     = busWrData;
      msk   = maskOf(mWid);
      dmask = (64'd1 << mPs) - 1;
      clr   = wr && a == 2 && d[0];
      adv   = mRun && tickIn && (mDiv >= dmask) && !clr;
      nxt   = (mCnt + 1) & msk;
      for (int i = 0; i < 4; i++) begin
        if (adv && nxt == (mCc[i] & msk)) mEvt[i] = 1'b1;
        else if (wr && a == 12 + i && !d[0]) mEvt[i] = 1'b0;
      end
      if (clr) mDiv = 0;
      else if (mRun && tickIn) mDiv = (mDiv >= dmask) ? 0 : mDiv + 1;
      if (clr) mCnt = 0;
      else if (adv) mCnt = nxt;
      if (wr && d[0] && a == 0) mRun = 1;
      else if (wr && d[0] && a == 1) mRun = 0;
      if (wr && a == 3) mWid = int'(d & 3);
      if (wr && a == 4) mPs = (d > 9) ? 9 : int'(d);
      if (wr && a >= 8 && a < 12) mCc[a - 8] = d & 64'hFFFF_FFFF;
    end
  end

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of the flags against the model
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) chk("R7/R8/R9 flags vs model", cmpEvent, mEvt);
  end

  always @(negedge clk) tickIn <= tickGap ? (cyc % 3 == 0) : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic wr(int a, longint unsigned d);
    busWrEn = 1; busAddr = 4'(a); busWrData = 32'(d);
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rdExp(string tag, int a, longint unsigned exp);
    busAddr = 4'(a);
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic rdModel(string tag, int a);
    busAddr = 4'(a);
    #1;
    chk(tag, busRdData, modelRead(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : stim
    longint unsigned held;
    rstN = 0; busWrEn = 0; busAddr = '0; busWrData = '0; tickIn = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rdExp("R1 count", 5, 0);
    rdExp("R1 width", 3, 0);
    rdExp("R1 prescale", 4, 0);
    for (int i = 0; i < 4; i++) rdExp("R1 flag", 12 + i, 0);
    // R11 unmapped and trigger reads
    rdExp("R11 idx0", 0, 0);
    rdExp("R11 idx6", 6, 0);

    // R2 trigger written with bit0 clear does nothing
    wr(0, 0);
    idle(10);
    rdExp("R2 count after zero write", 5, 0);

    // R7 compare hit
    wr(8, 5); wr(9, 100); wr(10, 16'h300); wr(11, 16'h400);
    rdModel("R7 cc readback", 9);
    wr(0, 1);
    idle(12);
    chk("R7 channel 0 hit", cmpEvent[0], 1);
    chk("R7 channel 1 not yet", cmpEvent[1], 0);
    rdModel("R2 count running", 5);

    // R3 halt and resume
    wr(1, 1);
    busAddr = 4'd5; #1; held = busRdData;
    chk("R3 halted count model", held, modelRead(5));
    idle(20);
    rdExp("R3 halted count held", 5, held);
    wr(0, 1);
    idle(5);
    rdModel("R3 resumed count", 5);

    // R8 sticky and clear rules
    wr(12, 1);
    rdExp("R8 write one keeps flag", 12, 1);
    wr(12, 0);
    rdExp("R8 write zero clears flag", 12, 0);

    // R10 compare value behind the counter, 8-bit width
    wr(3, 1);
    rdModel("R6 count masked to 8 bits", 5);
    wr(10, (mCnt - 10) & 64'hFF);
    wr(14, 0);
    idle(100);
    chk("R10 no event before wrap", cmpEvent[2], 0);
    idle(300);
    chk("R10 event after wrap", cmpEvent[2], 1);

    // R9 clear held on channel 3 while hits occur
    wr(11, 7);
    flagSeen = 0;
    busWrEn = 1; busAddr = 4'd15; busWrData = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (cmpEvent[3]) flagSeen = 1;
    end
    busWrEn = 0;
    chk("R9 hit wins over clear", flagSeen, 1);

    // R5 prescale clamp and division
    wr(4, 15);
    rdExp("R5 prescale clamp", 4, 9);
    wr(4, 2);
    tickGap = 1;
    wr(2, 1);
    idle(200);
    rdModel("R5 count with prescale 2", 5);
    tickGap = 0;
    wr(4, 0);
    idle(7);
    rdModel("R5 count with prescale 0", 5);

    // R4 zeroing while ticking
    wr(2, 1);
    rdExp("R4 count zeroed", 5, 0);

    // R6 16-bit wrap
    wr(3, 0);
    wr(8, 3);
    wr(12, 0);
    wr(2, 1);
    idle(100);
    chk("R6 hit before wrap", cmpEvent[0], 1);
    wr(12, 0);
    chk("R6 flag cleared", cmpEvent[0], 0);
    idle(65600);
    chk("R6 hit again after 16-bit wrap", cmpEvent[0], 1);
    rdModel("R6 count after wrap", 5);
    wr(3, 3);
    rdExp("R6 width code 32", 3, 3);
    rdModel("R6 count 32-bit", 5);
    wr(3, 2);
    idle(3);
    rdModel("R6 count 24-bit", 5);
    rdModel("R11 cc3 readback", 11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule